// File: doc/BRIEF.md
# Packed Decimal Signed Subtractor

This block computes A minus B for two signed packed-decimal operands and returns a signed packed-decimal result together with a four-bit condition code. Each operand carries 31 binary-coded decimal digits above a sign nibble. One control bit picks which of two positive sign encodings the result uses. A negative result always takes a single fixed negative encoding.

The datapath is digit-serial. A start strobe captures both operands and the preference bit. Both signs are classified and every digit is validated in the capture cycle. The operands are then ordered by magnitude, so that a subtraction never ends with a borrow. A single decimal adder/subtractor then walks the digits from least to most significant, one digit per clock. After the last digit the result, the condition code and a one-cycle done pulse are registered. The outputs hold their values until the next operation completes.

A difference that needs 32 digits is truncated to its low 31 digits and flagged. Operands with a non-decimal digit or an unknown sign code give a condition code that carries only the summary flag.

Top module: `pdec_sub`

## Requirements
- R1: Operand layout: bits 127..4 hold 31 BCD digits, most significant digit in bits 127..124, and bits 3..0 hold the sign. Sign codes 0xA, 0xC, 0xE and 0xF are positive, 0xB and 0xD are negative, and 0x0..0x9 are invalid. The result uses the same layout.
- R2: Condition code layout: bit 3 is less-than-zero, bit 2 is greater-than-zero, bit 1 is equal-to-zero and bit 0 is the overflow/invalid summary. For valid operands exactly one of bits 3..1 is set.
- R3: An exact difference of zero gives all-zero digits and condition 0b0010. The sign is 0xC when the preference bit is 0 and 0xF when it is 1.
- R4: A positive difference gives condition bit 2 and the 0xC/0xF sign selected by the preference bit.
- R5: A negative difference gives condition bit 3 and sign 0xD, whatever the preference bit.
- R6: When the magnitude of the difference exceeds 31 digits, the result keeps its low 31 digits and condition bit 0 is set in addition to the sign flag.
- R7: A digit above 9 or an invalid sign code in either operand makes the condition code exactly 0b0001.
- R8: A zero result always carries the positive encoding, even when both operands are negative zeros.
- R9: done_o pulses for one cycle, NDIG+1 clocks after the clock edge that accepts start_i. res_o and cond_o change only with that pulse and hold until the next one.
- R10: A start_i that arrives while an operation is in flight is ignored. The running operation finishes with its own operands and produces no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| a_i | input | 128 | Minuend, packed decimal |
| b_i | input | 128 | Subtrahend, packed decimal |
| pref_i | input | 1 | Positive-sign choice: 0 gives 0xC, 1 gives 0xF |
| res_o | output | 128 | Difference, packed decimal |
| cond_o | output | 4 | Condition code {LT, GT, EQ, SO} |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties are checked on every cycle. They cover the shape of the condition code, the 0xD sign whenever less-than is reported, zero digits with a non-negative sign whenever equal is reported, the single-cycle done pulse, the stability of the outputs between completions, and the uninterrupted digit count while busy. Numeric correctness cannot be expressed as a property: the correct digits after truncation, the right flag for each combination of signs, the 0xC/0xF choice and the invalid-code detection all need the bench's scenarios. The bench compares these against an arithmetic model and against hand-worked boundary vectors.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  localparam logic [3:0] SGN_POS_STD = 4'hC;
  localparam logic [3:0] SGN_POS_ALT = 4'hF;
  localparam logic [3:0] SGN_NEG     = 4'hD;
  localparam logic [3:0] DIGIT_MAX   = 4'd9;
endpackage

// File: rtl/pdec_sign_decode.sv
module pdec_sign_decode (
  input  logic [3:0] code_i,
  output logic       valid_o,
  output logic       neg_o
);
  always_comb begin
    unique case (code_i)
      4'hA, 4'hC, 4'hE, 4'hF: begin valid_o = 1'b1; neg_o = 1'b0; end
      4'hB, 4'hD:             begin valid_o = 1'b1; neg_o = 1'b1; end
      default:                begin valid_o = 1'b0; neg_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/pdec_digit_check.sv
module pdec_digit_check #(
  parameter int NDIG = 31
) (
  input  logic [NDIG*4-1:0] mag_i,
  output logic              ok_o
);
  import pdec_pkg::*;
  logic [NDIG-1:0] dig_ok;
  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    assign dig_ok[i] = (mag_i[i*4 +: 4] <= DIGIT_MAX);
  end
  assign ok_o = &dig_ok;
endmodule

// File: rtl/pdec_digit_alu.sv
module pdec_digit_alu (
  input  logic [3:0] x_i,
  input  logic [3:0] y_i,
  input  logic       c_i,
  input  logic       sub_i,
  output logic [3:0] d_o,
  output logic       c_o
);
  logic [4:0] raw;
  logic [4:0] adj;
  always_comb begin
    if (sub_i) begin
      raw = {1'b0, x_i} - {1'b0, y_i} - {4'd0, c_i};
      adj = raw + 5'd10;
      c_o = raw[4];
      d_o = raw[4] ? adj[3:0] : raw[3:0];
    end else begin
      raw = {1'b0, x_i} + {1'b0, y_i} + {4'd0, c_i};
      adj = raw - 5'd10;
      c_o = (raw > 5'd9);
      d_o = c_o ? adj[3:0] : raw[3:0];
    end
  end
endmodule

// File: rtl/pdec_sub.sv
module pdec_sub #(
  parameter int NDIG = 31
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [(NDIG+1)*4-1:0] a_i,
  input  logic [(NDIG+1)*4-1:0] b_i,
  input  logic                  pref_i,
  output logic [(NDIG+1)*4-1:0] res_o,
  output logic [3:0]            cond_o,
  output logic                  done_o
);
  import pdec_pkg::*;

  localparam int W  = (NDIG + 1) * 4;
  localparam int MW = NDIG * 4;
  localparam int CW = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam logic [CW-1:0] LAST = CW'(NDIG - 1);

  // operand classification
  logic a_sok, a_neg, b_sok, b_neg, a_dok, b_dok;
  logic [MW-1:0] mag_a, mag_b;
  assign mag_a = a_i[W-1:4];
  assign mag_b = b_i[W-1:4];

  pdec_sign_decode u_sa (.code_i(a_i[3:0]), .valid_o(a_sok), .neg_o(a_neg));
  pdec_sign_decode u_sb (.code_i(b_i[3:0]), .valid_o(b_sok), .neg_o(b_neg));
  pdec_digit_check #(.NDIG(NDIG)) u_da (.mag_i(mag_a), .ok_o(a_dok));
  pdec_digit_check #(.NDIG(NDIG)) u_db (.mag_i(mag_b), .ok_o(b_dok));

  // valid BCD magnitudes order the same way as plain unsigned vectors
  logic a_ge_b, eff_sub, go;
  assign a_ge_b  = (mag_a >= mag_b);
  assign eff_sub = (a_neg == b_neg);

  // sequencing and serial datapath state
  logic          busy, fin;
  logic [CW-1:0] cnt;
  logic [MW-1:0] x_sr, y_sr, acc;
  logic          cy, nz, sub_q, neg_q, bad_q, pref_q;
  logic [3:0]    dig;
  logic          dig_co;

  assign go = start_i && !busy && !fin;

  pdec_digit_alu u_alu (
    .x_i(x_sr[3:0]), .y_i(y_sr[3:0]), .c_i(cy), .sub_i(sub_q),
    .d_o(dig), .c_o(dig_co)
  );

  // result assembly from the finished accumulator
  logic       ov, is_zero, res_neg;
  logic [3:0] sgn, cond_n;
  always_comb begin
    ov      = cy & ~sub_q;
    is_zero = ~nz & ~ov;
    res_neg = neg_q & ~is_zero;
    sgn     = res_neg ? SGN_NEG : (pref_q ? SGN_POS_ALT : SGN_POS_STD);
    if (bad_q)        cond_n = 4'b0001;
    else if (is_zero) cond_n = 4'b0010;
    else if (res_neg) cond_n = {3'b100, ov};
    else              cond_n = {3'b010, ov};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      fin    <= 1'b0;
      cnt    <= '0;
      x_sr   <= '0;
      y_sr   <= '0;
      acc    <= '0;
      cy     <= 1'b0;
      nz     <= 1'b0;
      sub_q  <= 1'b0;
      neg_q  <= 1'b0;
      bad_q  <= 1'b0;
      pref_q <= 1'b0;
      res_o  <= '0;
      cond_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go) begin
        x_sr   <= (eff_sub && !a_ge_b) ? mag_b : mag_a;
        y_sr   <= (eff_sub && !a_ge_b) ? mag_a : mag_b;
        sub_q  <= eff_sub;
        neg_q  <= eff_sub ? (a_ge_b ? a_neg : ~a_neg) : a_neg;
        bad_q  <= ~(a_sok & b_sok & a_dok & b_dok);
        pref_q <= pref_i;
        cy     <= 1'b0;
        nz     <= 1'b0;
        cnt    <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        x_sr <= x_sr >> 4;
        y_sr <= y_sr >> 4;
        acc  <= {dig, acc[MW-1:4]};
        cy   <= dig_co;
        nz   <= nz | (dig != 4'd0);
        if (cnt == LAST) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (fin) begin
        fin    <= 1'b0;
        res_o  <= {acc, sgn};
        cond_o <= cond_n;
        done_o <= 1'b1;
      end
    end
  end

  AST_COND_SHAPE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (($countones(cond_o[3:1]) == 1) || (cond_o == 4'b0001))); // R2
  AST_NEG_SIGN: assert property (@(posedge clk) disable iff (rst)
    (done_o && cond_o[3]) |-> (res_o[3:0] == SGN_NEG)); // R5
  AST_ZERO_POS: assert property (@(posedge clk) disable iff (rst)
    (done_o && cond_o[1]) |-> ((res_o[W-1:4] == '0) && (res_o[3:0] != SGN_NEG))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fin |=> ($stable(res_o) && $stable(cond_o))); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy && start_i && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1)); // R10
endmodule

// File: tb/tb_pdec_sub.sv
module tb_pdec_sub;
  localparam int NDIG = 31;
  localparam int W = (NDIG + 1) * 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, pref = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] res;
  logic [3:0]   cond;
  logic         done;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdec_sub #(.NDIG(NDIG)) dut (
    .clk(clk), .rst(rst), .start_i(start), .a_i(a), .b_i(b), .pref_i(pref),
    .res_o(res), .cond_o(cond), .done_o(done)
  );

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         pref;
    logic         chk_res;
    logic [3:0]   cond;
    logic [W-1:0] res;
  } vec_t;

  localparam logic [123:0] NINES = {31{4'h9}};
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{ {NINES,4'hC}, {NINES,4'hC}, 1'b0, 1'b1, 4'b0010, {124'd0,4'hC} },          // R3
    '{ {NINES,4'hC}, {NINES,4'hC}, 1'b1, 1'b1, 4'b0010, {124'd0,4'hF} },          // R3
    '{ {NINES,4'hC}, {120'd0,4'h1,4'hD}, 1'b0, 1'b1, 4'b0101, {124'd0,4'hC} },    // R6
    '{ {NINES[123:4],4'h8,4'hC}, {120'd0,4'h1,4'hD}, 1'b1, 1'b1, 4'b0100, {NINES,4'hF} }, // R4
    '{ {124'd0,4'hC}, {120'd0,4'h1,4'hC}, 1'b1, 1'b1, 4'b1000, {120'd0,4'h1,4'hD} }, // R5
    '{ {NINES,4'hD}, {120'd0,4'h1,4'hC}, 1'b0, 1'b1, 4'b1001, {124'd0,4'hD} },    // R6
    '{ {120'd0,4'h1,4'hC}, {116'd0,8'hF0,4'h0}, 1'b0, 1'b0, 4'b0001, '0 },        // R7
    '{ {116'd0,4'hA,4'h3,4'hC}, {124'd0,4'hC}, 1'b1, 1'b0, 4'b0001, '0 },         // R7
    '{ {124'd0,4'hD}, {124'd0,4'hB}, 1'b0, 1'b1, 4'b0010, {124'd0,4'hC} },        // R8
    '{ {120'd0,4'h5,4'hA}, {120'd0,4'h3,4'hB}, 1'b0, 1'b1, 4'b0100, {120'd0,4'h8,4'hC} }, // R1
    '{ {120'd0,4'h3,4'hD}, {120'd0,4'h5,4'hB}, 1'b1, 1'b1, 4'b0100, {120'd0,4'h2,4'hF} }, // R1
    '{ {120'd0,4'h7,4'hA}, {120'd0,4'h9,4'hE}, 1'b0, 1'b1, 4'b1000, {120'd0,4'h2,4'hD} }, // R5
    '{ {120'd0,4'h5,4'h9}, {124'd0,4'hC}, 1'b0, 1'b0, 4'b0001, '0 }               // R7
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // arithmetic reference model
  function automatic logic [W-1:0] to_bin(input logic [123:0] m);
    logic [W-1:0] r = '0;
    for (int i = NDIG - 1; i >= 0; i--) r = r * 10 + W'(m[i*4 +: 4]);
    return r;
  endfunction

  function automatic logic [123:0] to_bcd(input logic [W-1:0] v);
    logic [123:0] m = '0;
    logic [W-1:0] t = v;
    for (int i = 0; i < NDIG; i++) begin
      m[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return m;
  endfunction

  function automatic logic sgn_neg(input logic [3:0] c);
    return (c == 4'hB) || (c == 4'hD);
  endfunction

  task automatic model(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic ip,
                       output logic [W-1:0] er, output logic [3:0] ec);
    logic signed [W+8:0] va, vb, df;
    logic [W-1:0] mag, lim;
    logic ov, ng;
    lim = 1;
    for (int i = 0; i < NDIG; i++) lim = lim * 10;
    va = $signed({9'd0, to_bin(ia[W-1:4])});
    vb = $signed({9'd0, to_bin(ib[W-1:4])});
    if (sgn_neg(ia[3:0])) va = -va;
    if (sgn_neg(ib[3:0])) vb = -vb;
    df  = va - vb;
    ng  = df < 0;
    mag = W'(ng ? -df : df);
    ov  = mag >= lim;
    mag = mag % lim;
    if (df == 0) begin
      ec = 4'b0010;
      er = {124'd0, ip ? 4'hF : 4'hC};
    end else begin
      ec = ng ? {3'b100, ov} : {3'b010, ov};
      er = {to_bcd(mag), ng ? 4'hD : (ip ? 4'hF : 4'hC)};
    end
  endtask

  // drive one operation, return results and observed latency
  task automatic run_op(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic ip,
                        output int lat);
    @(negedge clk);
    a = ia; b = ib; pref = ip; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 200);
  endtask

  function automatic logic [W-1:0] rand_op();
    logic [123:0] m = '0;
    int nd = $urandom_range(1, NDIG);
    logic [3:0] codes [6] = '{4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
    for (int i = 0; i < nd; i++) m[i*4 +: 4] = 4'($urandom_range(0, 9));
    return {m, codes[$urandom_range(0, 5)]};
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [W-1:0] er, er2;
    logic [3:0] ec, ec2;
    logic [W-1:0] hold_res;
    int extra;

    repeat (3) @(negedge clk);
    check("R9 reset done", W'(done), '0);
    check("R9 reset res", res, '0);
    check("R2 reset cond", W'(cond), '0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].a, VECS[i].b, VECS[i].pref, lat);
      check($sformatf("R9 latency vec%0d", i), W'(lat), W'(NDIG + 1));
      check($sformatf("R2 cond vec%0d", i), W'(cond), W'(VECS[i].cond));
      if (VECS[i].chk_res) check($sformatf("R6 result vec%0d", i), res, VECS[i].res);
    end

    // random valid operands against the model (R1 R3 R4 R5 R6)
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] ra, rb;
      logic rp;
      ra = rand_op();
      rb = (i % 8 == 0) ? {ra[W-1:4], (ra[3:0] == 4'hC) ? 4'hA : 4'hE} : rand_op();
      rp = 1'($urandom_range(0, 1));
      model(ra, rb, rp, er, ec);
      run_op(ra, rb, rp, lat);
      check($sformatf("R4 R5 random cond %0d", i), W'(cond), W'(ec));
      check($sformatf("R1 random result %0d", i), res, er);
    end

    // start while busy is ignored (R10), outputs held (R9)
    model({120'd0,4'h4,4'hC}, {120'd0,4'h6,4'hC}, 1'b0, er, ec);
    model({NINES,4'hC}, {120'd0,4'h1,4'hD}, 1'b1, er2, ec2);
    @(negedge clk);
    a = {120'd0,4'h4,4'hC}; b = {120'd0,4'h6,4'hC}; pref = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    a = {NINES,4'hC}; b = {120'd0,4'h1,4'hD}; pref = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    check("R10 first operands kept", res, er);
    check("R10 first cond kept", W'(cond), W'(ec));
    hold_res = res;
    extra = 0;
    for (int k = 0; k < NDIG + 10; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R10 no extra done", W'(extra), '0);
    check("R9 result held", res, hold_res);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule